// File: doc/BRIEF.md
# CEC Frame Receiver with Destination Filter

This block listens to an already synchronised single-wire CEC line and turns the timing of its falling edges into frames. Every low pulse is timed from its falling edge. The pulse length must fall into the start window or into one of the two data-bit windows, and the bit value is taken from the line level at a fixed delay after the falling edge. A frame is a start bit followed by 10-bit bytes: eight data bits sent MSB first, an end-of-message bit, and an acknowledge bit.

When a frame completes, the receiver decides whether to keep it. It compares the destination nibble of the first byte with the configured own address, or it keeps every frame when that address is 0xF. A kept frame is streamed into an external shared buffer one byte per cycle, and then the length and a dirty flag are updated. Whatever its destination, the source nibble of every header marks a bit in a 16-bit vector of addresses in use. For frames sent to its own address, the block asks the line driver to hold the line low through each acknowledge bit. A reader clears the dirty flag after it has consumed the buffer.

All timing constants are expressed in 50 µs units. The parameter `UNIT_CYC` gives the number of clock cycles in one unit.

Top module: `cec_rx_filter`

## Requirements
- R1: A start bit is accepted only if its low time is 3.5–3.9 ms and the time to the next falling edge is 4.3–4.7 ms. A start low pulse outside this range leaves the receiver idle, and the bits that follow are not decoded.
- R2: The value of each data bit is the line level 1.05 ms after its falling edge. Bytes are assembled MSB first, and the kept bytes are written to buffer addresses 0, 1, 2, … in the order they were received, one per cycle.
- R3: When the own address is not 0xF, a frame is kept only if the low nibble (bits 3:0) of its first byte equals the own address.
- R4: When the own address is 0xF, every complete frame is kept, whatever its destination.
- R5: A frame that is not kept causes no buffer write and leaves the length and the dirty flag unchanged.
- R6: After a kept frame of N bytes, exactly N writes take place, the length output becomes N (1 to 16), and dirty becomes 1. Buffer bytes at or beyond N are not written.
- R7: For every decoded header, including headers of frames that are not kept, bit `header[7:4]` of the taken vector is set. Bits are never cleared except by reset.
- R8: For frames whose destination equals a non-0xF own address, `ack_pull` is high from the falling edge of each acknowledge bit for 1.5 ms. It is never high for any other frame.
- R9: A data low pulse between the two bit windows (neither 0.4–0.8 ms nor 1.3–1.7 ms) aborts the frame without any buffer write.
- R10: A data bit is accepted only if the next falling edge comes 2.05–2.75 ms after the previous one. An earlier edge aborts the frame without any write.
- R11: If a sixteenth byte carries end-of-message 0, the frame is aborted without any write.
- R12: A pulse on `dirty_clr` clears dirty. A commit in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cec_line | input | 1 | Synchronised CEC line level |
| own_addr | input | 4 | Own logical address; 0xF captures all frames |
| dirty_clr | input | 1 | Clears the dirty flag |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(MAX_BYTES) | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| rx_len | output | $clog2(MAX_BYTES+1) | Length of the last kept frame |
| dirty | output | 1 | Set when a new frame has been stored |
| taken | output | 16 | Source addresses seen on the bus |
| ack_pull | output | 1 | Request to drive the line low for acknowledge |

## Verification
Frames are sent under several settings: addressed to the own address, addressed elsewhere, and under the 0xF capture-all setting. Together these separate filtering from storage and show whether the acknowledge is confined to directly addressed frames. A single-byte poll and a 16-byte frame bound the length, and they show that bytes beyond a short frame are left untouched. Distorted stimulus then tells whether each timing window is enforced on its own: a short start pulse, a bit pulse that fits neither window, an early next edge, and an over-long frame. The taken vector is compared after both kept and dropped frames.

// File: rtl/cec_rx_filter.sv
module cec_rx_filter #(
  parameter int UNIT_CYC  = 2500,
  parameter int MAX_BYTES = 16,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int PW = $clog2(UNIT_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cec_line,
  input  logic [3:0]    own_addr,
  input  logic          dirty_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [LW-1:0] rx_len,
  output logic          dirty,
  output logic [15:0]   taken,
  output logic          ack_pull
);
  localparam logic [6:0] T_SAMP  = 7'd21;
  localparam logic [6:0] T_DEC   = 7'd34;
  localparam logic [6:0] T_ACK   = 7'd30;
  localparam logic [6:0] T_MAX   = 7'd127;
  localparam logic [6:0] ONE_LO  = 7'd8,  ONE_HI  = 7'd16;
  localparam logic [6:0] ZER_LO  = 7'd26, ZER_HI  = 7'd34;
  localparam logic [6:0] STL_LO  = 7'd70, STL_HI  = 7'd78;
  localparam logic [6:0] STP_LO  = 7'd86, STP_HI  = 7'd94;
  localparam logic [6:0] BTP_LO  = 7'd41, BTP_HI  = 7'd55;

  typedef enum logic [2:0] {IDLE, ST_LOW, ST_HIGH, BIT_LOW, BIT_HIGH} st_t;

  st_t            st;
  logic           prev, samp, eom, ack_me, keep, drn;
  logic [PW-1:0]  pre;
  logic [6:0]     t;
  logic [3:0]     bidx;
  logic [AW-1:0]  byx, dcnt;
  logic [LW-1:0]  dlen;
  logic [7:0]     sh;
  logic [7:0]     frm [MAX_BYTES];

  function automatic logic inr(input logic [6:0] v, input logic [6:0] lo, input logic [6:0] hi);
    return v >= lo && v <= hi;
  endfunction

  wire       fall  = prev & ~cec_line;
  wire       rise  = ~prev & cec_line;
  wire       tick  = pre == PW'(UNIT_CYC - 1);
  wire [7:0] nbyte = {sh[6:0], samp};
  wire       dec   = st == BIT_HIGH && !fall && tick && t == T_DEC;
  wire       cmt   = dec && bidx == 4'd9 && eom && keep;

  assign ack_pull = st == BIT_LOW && bidx == 4'd9 && ack_me && t < T_ACK;
  assign wr_en    = drn;
  assign wr_addr  = dcnt;
  assign wr_data  = frm[dcnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b1; pre <= '0; t <= '0; samp <= 1'b1;
    end else begin
      prev <= cec_line;
      if (fall) begin
        pre <= '0; t <= '0;
      end else if (tick) begin
        pre <= '0;
        if (t != T_MAX) t <= t + 7'd1;
      end else pre <= pre + PW'(1);
      if (t == T_SAMP) samp <= cec_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; bidx <= '0; byx <= '0; sh <= '0;
      eom <= 1'b0; ack_me <= 1'b0; keep <= 1'b0; taken <= '0;
    end else begin
      case (st)
        IDLE:    if (fall) st <= ST_LOW;
        ST_LOW:  if (rise) st <= inr(t, STL_LO, STL_HI) ? ST_HIGH : IDLE;
        ST_HIGH: if (fall) begin
          if (inr(t, STP_LO, STP_HI)) begin
            st <= BIT_LOW; bidx <= '0; byx <= '0; ack_me <= 1'b0; keep <= 1'b0;
          end else st <= ST_LOW;
        end
        BIT_LOW: begin
          if (rise) st <= (inr(t, ONE_LO, ONE_HI) || inr(t, ZER_LO, ZER_HI)) ? BIT_HIGH : IDLE;
          else if (t > ZER_HI) st <= ST_LOW;
        end
        BIT_HIGH: begin
          if (fall) st <= inr(t, BTP_LO, BTP_HI) ? BIT_LOW : ST_LOW;
          else if (dec) begin
            bidx <= bidx + 4'd1;
            if (bidx < 4'd8) begin
              sh <= nbyte;
              if (bidx == 4'd7 && byx == '0) begin
                taken[nbyte[7:4]] <= 1'b1;
                ack_me <= nbyte[3:0] == own_addr && own_addr != 4'hF;
                keep   <= nbyte[3:0] == own_addr || own_addr == 4'hF;
              end
            end else if (bidx == 4'd8) begin
              eom <= samp;
              if (!samp && byx == AW'(MAX_BYTES - 1)) st <= IDLE;
            end else begin
              bidx <= '0;
              byx  <= byx + AW'(1);
              if (eom) st <= IDLE;
            end
          end else if (t > BTP_HI) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (dec && bidx == 4'd7) frm[byx] <= nbyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drn <= 1'b0; dcnt <= '0; dlen <= '0; rx_len <= '0; dirty <= 1'b0;
    end else begin
      if (dirty_clr) dirty <= 1'b0;
      if (cmt) begin
        drn <= 1'b1; dcnt <= '0; dlen <= LW'(byx) + LW'(1);
      end else if (drn) begin
        dcnt <= dcnt + AW'(1);
        if (LW'(dcnt) + LW'(1) == dlen) begin
          drn <= 1'b0; rx_len <= dlen; dirty <= 1'b1;
        end
      end
    end
  end
endmodule

module cec_rx_filter_chk #(
  parameter int MAX_BYTES = 16,
  localparam int AW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cec_line,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] rx_len,
  input logic          dirty,
  input logic [15:0]   taken,
  input logic          ack_pull
);
  assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> 32'(wr_addr) < MAX_BYTES);
  assert_len_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_len) <= MAX_BYTES);
  assert_dirty_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty) |-> $past(wr_en));
  assert_wr_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + AW'(1));
  assert_taken_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (taken & $past(taken)) == $past(taken));
  assert_ack_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> ($past(cec_line, 2) && !$past(cec_line)));
endmodule

bind cec_rx_filter cec_rx_filter_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cec_line(cec_line), .wr_en(wr_en), .wr_addr(wr_addr),
  .rx_len(rx_len), .dirty(dirty), .taken(taken), .ack_pull(ack_pull)
);

// File: tb/tb_cec_rx_filter.sv
module tb_cec_rx_filter;
  localparam int U = 4;

  logic clk = 1'b0, rst_n = 1'b0, drv = 1'b1, dirty_clr = 1'b0;
  logic [3:0] own_addr = 4'h4;
  logic wr_en, dirty, ack_pull;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] rx_len;
  logic [15:0] taken;
  wire cec_line = drv & ~ack_pull;

  int checks = 0, fails = 0, wcnt = 0, ackc = 0;
  logic [7:0] cap [16];

  always #10 clk = ~clk;

  cec_rx_filter #(.UNIT_CYC(U)) dut (
    .clk(clk), .rst_n(rst_n), .cec_line(cec_line), .own_addr(own_addr),
    .dirty_clr(dirty_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_len(rx_len), .dirty(dirty), .taken(taken), .ack_pull(ack_pull));

  always @(posedge clk) begin
    if (wr_en) begin cap[wr_addr] = wr_data; wcnt++; end
    if (ack_pull) ackc++;
  end

  // {own, n, b0, b1, b2, keep, ack}
  localparam logic [33:0] VEC [5] = '{
    {4'h4, 4'd2, 8'h04, 8'h36, 8'h00, 1'b1, 1'b1},
    {4'h4, 4'd3, 8'h05, 8'h44, 8'h01, 1'b0, 1'b0},
    {4'hF, 4'd3, 8'h3F, 8'h82, 8'h10, 1'b1, 1'b0},
    {4'h4, 4'd1, 8'h14, 8'h00, 8'h00, 1'b1, 1'b1},
    {4'hF, 4'd2, 8'h8B, 8'h9A, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wait_u(input int n); repeat (n * U) @(negedge clk); endtask
  task automatic pulse(input int lo, input int per);
    drv = 1'b0; wait_u(lo); drv = 1'b1; wait_u(per - lo);
  endtask
  task automatic send_start; pulse(74, 90); endtask
  task automatic send_bit(input logic b); pulse(b ? 12 : 30, 48); endtask
  task automatic send_byte(input logic [7:0] d, input logic e);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(e);
    send_bit(1'b1);
  endtask
  task automatic clear_dirty;
    dirty_clr = 1'b1; @(negedge clk); dirty_clr = 1'b0; @(negedge clk);
    check(dirty == 1'b0, "R12 dirty cleared", dirty, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] plen;
    logic [7:0] bb [3];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_len == 0 && dirty == 0, "R6 reset len/dirty", rx_len, 0);
    check(taken == 0, "R7 reset taken", taken, 0);
    check(!wr_en && !ack_pull, "R8 reset outputs idle", ack_pull, 0);
    wait_u(10);

    for (int k = 0; k < 5; k++) begin
      own_addr = VEC[k][33:30];
      bb[0] = VEC[k][25:18]; bb[1] = VEC[k][17:10]; bb[2] = VEC[k][9:2];
      plen = rx_len; wcnt = 0; ackc = 0;
      send_start;
      for (int j = 0; j < int'(VEC[k][29:26]); j++)
        send_byte(bb[j], j == int'(VEC[k][29:26]) - 1);
      wait_u(4);
      if (VEC[k][1]) begin
        check(wcnt == int'(VEC[k][29:26]), own_addr == 4'hF ? "R4 writes" : "R3 writes", wcnt, int'(VEC[k][29:26]));
        check(rx_len == 5'(VEC[k][29:26]) && dirty, "R6 length and dirty", rx_len, int'(VEC[k][29:26]));
        for (int j = 0; j < int'(VEC[k][29:26]); j++)
          check(cap[j] == bb[j], "R2 byte content", cap[j], bb[j]);
        clear_dirty;
      end else begin
        check(wcnt == 0, "R5 no write", wcnt, 0);
        check(rx_len == plen && !dirty, "R5 length/dirty unchanged", rx_len, plen);
      end
      if (VEC[k][0])
        check(ackc >= 115 * int'(VEC[k][29:26]) && ackc <= 125 * int'(VEC[k][29:26]), "R8 ack length", ackc, 120 * int'(VEC[k][29:26]));
      else
        check(ackc == 0, "R8 no ack", ackc, 0);
      wait_u(20);
    end
    check(taken == 16'h010B, "R7 taken after table", taken, 16'h010B);

    // R1: start pulse too short
    own_addr = 4'h4; wcnt = 0; plen = rx_len;
    pulse(60, 90); send_byte(8'h24, 1'b0); send_byte(8'h11, 1'b1); wait_u(20);
    check(wcnt == 0 && rx_len == plen, "R1 bad start no write", wcnt, 0);
    check(taken == 16'h010B, "R1 no header decoded", taken, 16'h010B);

    // R9: bit low between windows
    wcnt = 0;
    send_start; send_bit(0); send_bit(0); pulse(20, 48);
    for (int i = 4; i >= 0; i--) send_bit(i == 2);
    send_bit(1); send_bit(1); wait_u(20);
    check(wcnt == 0 && rx_len == plen, "R9 invalid bit aborts", wcnt, 0);

    // R10: next falling edge too early
    wcnt = 0;
    send_start; pulse(30, 38);
    for (int i = 6; i >= 0; i--) send_bit(i == 2);
    send_bit(1); send_bit(1); wait_u(20);
    check(wcnt == 0 && rx_len == plen, "R10 early edge aborts", wcnt, 0);

    // R11: seventeen bytes, no end within sixteen
    wcnt = 0;
    send_start;
    for (int j = 0; j < 17; j++) send_byte(j == 0 ? 8'h24 : 8'(j), j == 16);
    wait_u(20);
    check(wcnt == 0 && !dirty, "R11 overlong frame dropped", wcnt, 0);

    // R6: maximum length frame under capture-all
    own_addr = 4'hF; wcnt = 0;
    send_start;
    for (int j = 0; j < 16; j++) send_byte(j == 0 ? 8'hCF : 8'(j * 17), j == 15);
    wait_u(4);
    check(wcnt == 16 && rx_len == 16, "R6 sixteen byte frame", rx_len, 16);
    check(cap[0] == 8'hCF && cap[15] == 8'hFF, "R2 last byte", cap[15], 8'hFF);
    check(taken == 16'h110F, "R7 final taken", taken, 16'h110F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule